// File: doc/BRIEF.md
# Pulse-Width Modulator with Pulse Spreading

This block is a single-channel pulse-width modulator. Its frame length is programmable from 2^7 to 2^16 counts. A free-running frame counter advances on every clock cycle where the count-enable input is high. The output is high for a number of counts per frame equal to the duty value. The select input can split the frame into a power-of-two number of equal slots. The high time is then shared evenly among those slots, which raises the output frequency by the slot count while keeping the average duty unchanged.

The duty, resolution and spread settings are captured into shadow registers at each frame boundary, so a frame never mixes old and new settings. The enable input parks the counter at zero and holds the output at its idle level. The invert input flips the output polarity.

Top module: `pwm_spread`

## Requirements
- R1: The frame is 2^N counts long. N is the value on `res_bits`, clamped to the range 7..16 (below 7 acts as 7, above 16 acts as 16).
- R2: With one slot, the output is high for the first `duty` counts of the frame (counts 0..duty-1) and low for the rest.
- R3: The slot count S is 2^(spread_sel + N - 10), limited to at least 1 and at most 512. Each slot is 2^N/S counts long.
- R4: In every slot the output is high for floor(duty/S) counts from the slot start. The first (duty mod S) slots of the frame each get one extra high count.
- R5: A duty value of 2^N or more keeps the output high for the whole frame.
- R6: Changes to `duty`, `res_bits` and `spread_sel` take effect only when the counter wraps from 2^N-1 to 0. While `enable` is low, the settings are captured every cycle.
- R7: While `enable` is low, the counter is held at 0 and the output sits at its idle level (`invert`). After `enable` rises, the first output reflects count 0.
- R8: When `invert` is 1, the output is the complement of the non-inverted waveform, and the idle level is high.
- R9: The counter advances only on cycles with `clk_en` high. On other cycles the count and the output hold.
- R10: The output is registered. It shows the value for the count held before each rising clock edge. After reset the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Count enable (stands in for the selected count clock) |
| enable | input | 1 | Channel run enable |
| invert | input | 1 | Output polarity invert |
| res_bits | input | 5 | Resolution N in bits (clamped to 7..16) |
| spread_sel | input | 2 | Pulse-spreading select |
| duty | input | 16 | High counts per frame |
| pwm_out | output | 1 | PWM output |

## Verification
The bench compares every output cycle against a model written from the requirements.

- **Slot clamps.** It covers the lower slot clamp (one slot at N=7 or N=9), a mid case (32 slots at N=12) and the upper clamp (512 slots at N=16). A wrong clamp shows up as the wrong number of pulses per frame.
- **Remainder handling.** Duty values are chosen with a non-zero remainder over S. A design that drops the remainder, or gives it to the last slots, loses high counts or shifts them to the wrong place.
- **Full duty.** A duty at or above 2^N is tested. A design with a narrow comparison would wrap and emit short pulses instead of a solid high.
- **Mid-frame update.** A duty change is made in the middle of a frame. A design without frame-boundary shadowing would blend the two duty values within one frame.
- **Count gating.** Cycles with `clk_en` low are mixed in. A counter that ignores the gate would shorten every pulse.

// File: rtl/pwm_spread.sv
module pwm_spread #(
  parameter int CW        = 16,
  parameter int MIN_RES   = 7,
  parameter int SLOT_LOGM = 9,
  parameter int SPR_BASE  = 10,
  localparam int RW       = $clog2(CW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          enable,
  input  logic          invert,
  input  logic [RW-1:0] res_bits,
  input  logic [1:0]    spread_sel,
  input  logic [CW-1:0] duty,
  output logic          pwm_out
);

  logic [CW-1:0] cnt, sh_duty, frame_last;
  logic [RW-1:0] sh_res, res_eff, slog, llog;
  logic [1:0]    sh_ps;
  logic [RW:0]   esum;
  logic [CW-1:0] pos, slot, base, rem;
  logic          full, wrap, load, high;

  assign res_eff = (res_bits < RW'(MIN_RES)) ? RW'(MIN_RES) :
                   (res_bits > RW'(CW))      ? RW'(CW)      : res_bits;

  assign frame_last = CW'((33'd1 << sh_res) - 33'd1);
  assign wrap       = clk_en && (cnt == frame_last);
  assign load       = !enable || wrap;

  assign esum = (RW+1)'(sh_ps) + (RW+1)'(sh_res);
  assign slog = (esum <= (RW+1)'(SPR_BASE))             ? '0 :
                (esum >= (RW+1)'(SPR_BASE + SLOT_LOGM)) ? RW'(SLOT_LOGM) :
                RW'(esum - (RW+1)'(SPR_BASE));
  assign llog = sh_res - slog;

  assign pos  = cnt & CW'((33'd1 << llog) - 33'd1);
  assign slot = cnt >> llog;
  assign base = sh_duty >> slog;
  assign rem  = sh_duty & CW'((33'd1 << slog) - 33'd1);
  assign full = sh_duty > frame_last;
  assign high = full ||
                ({1'b0, pos} < ({1'b0, base} + {{CW{1'b0}}, (slot < rem)}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_duty <= '0;
      sh_res  <= RW'(MIN_RES);
      sh_ps   <= '0;
    end else if (load) begin
      sh_duty <= duty;
      sh_res  <= res_eff;
      sh_ps   <= spread_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!enable) cnt <= '0;
    else if (wrap)    cnt <= '0;
    else if (clk_en)  cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_out <= 1'b0;
    else        pwm_out <= enable ? (high ^ invert) : invert;
  end

endmodule

// File: rtl/pwm_spread_chk.sv
module pwm_spread_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en,
  input logic          enable,
  input logic          invert,
  input logic          pwm_out,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] sh_duty,
  input logic [CW-1:0] frame_last
);

  assert_frame_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= frame_last);

  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !(clk_en && cnt == frame_last)) |=> $stable(sh_duty));

  assert_idle_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt == '0));

  assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (pwm_out == $past(invert)));

  assert_gate_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !clk_en) |=> $stable(cnt));

  assert_full_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && sh_duty > frame_last) |=> (pwm_out == !$past(invert)));

endmodule

bind pwm_spread pwm_spread_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .enable(enable),
  .invert(invert), .pwm_out(pwm_out), .cnt(cnt), .sh_duty(sh_duty),
  .frame_last(frame_last)
);

// File: tb/pwm_spread_bench.sv
`timescale 1ns/1ps
module pwm_spread_bench;
  logic        clk = 1'b0, rst_n = 1'b0, clk_en = 1'b0, enable = 1'b0, invert = 1'b0;
  logic [4:0]  res_bits = 5'd9;
  logic [1:0]  spread_sel = 2'd0;
  logic [15:0] duty_i = '0;
  logic        pwm_out;
  int          n_run = 0, n_fail = 0;

  pwm_spread u_pwm_spread (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .enable(enable), .invert(invert),
    .res_bits(res_bits), .spread_sel(spread_sel), .duty(duty_i), .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit ref_high(input int n, input int ps, input int d, input int k);
    int e, s, len;
    e = ps + n - 10;
    if (e < 0) e = 0;
    if (e > 9) e = 9;
    s = 1 << e;
    len = (1 << n) / s;
    if (d >= (1 << n)) return 1'b1;
    return (k % len) < (d / s + (((k / len) < (d % s)) ? 1 : 0));
  endfunction

  task automatic play(input int rb, input int ps, input int d, input bit inv,
                      input int frames, input bit gate, input int new_d,
                      input string req);
    int n, size, k, fr, cur, hi, errs, cyc, bad_k, bad_v;
    bit ce, ev;
    n = (rb < 7) ? 7 : (rb > 16) ? 16 : rb;
    size = 1 << n;
    k = 0; fr = 0; cur = d; hi = 0; errs = 0; cyc = 0; bad_k = -1; bad_v = 0;
    @(negedge clk);
    enable = 1'b0; clk_en = 1'b1; res_bits = 5'(rb); spread_sel = 2'(ps);
    duty_i = 16'(d); invert = inv;
    @(negedge clk);
    @(negedge clk);
    enable = 1'b1;
    while (fr < frames) begin
      ce = gate ? ((cyc % 3) != 1) : 1'b1;
      clk_en = ce;
      cyc++;
      if (new_d >= 0 && fr == 0 && k == size / 2) duty_i = 16'(new_d);
      @(posedge clk);
      ev = ref_high(n, ps, cur, k) ^ inv;
      if (ce) begin
        if (fr == 0 && (ev ^ inv)) hi++;
        k++;
        if (k == size) begin
          k = 0; fr++; cur = duty_i;
        end
      end
      @(negedge clk);
      if (pwm_out !== ev) begin
        errs++;
        if (bad_k < 0) begin bad_k = cyc; bad_v = pwm_out; end
      end
    end
    check(errs == 0, {req, " waveform per cycle (first bad cycle in actual)"},
          (errs == 0) ? 0 : bad_k, 0);
    check(hi == ((d < size) ? d : size), {req, " high counts in first frame"},
          hi, (d < size) ? d : size);
    enable = 1'b0;
    clk_en = 1'b1;
  endtask

  task automatic test_reset();
    check(pwm_out === 1'b0, "R10 reset output low", int'(pwm_out), 0);
  endtask

  task automatic test_disable();
    int bad = 0;
    @(negedge clk);
    enable = 1'b0; invert = 1'b1; duty_i = 16'd200; res_bits = 5'd9;
    for (int i = 0; i < 20; i++) begin
      clk_en = i[0];
      @(negedge clk);
      if (pwm_out !== 1'b1) bad++;
    end
    check(bad == 0, "R7 R8 idle level high while disabled", bad, 0);
    invert = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(pwm_out === 1'b0, "R7 idle level low while disabled", int'(pwm_out), 0);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #5 test_reset();
    #30 rst_n = 1'b1;
    test_disable();
    play(9, 0, 128, 1'b0, 2, 1'b0, -1, "R1 R2 N9 single slot");
    play(12, 3, 1000, 1'b0, 1, 1'b0, -1, "R3 R4 N12 32 slots");
    play(16, 3, 40001, 1'b0, 1, 1'b0, -1, "R3 R4 N16 512 slot clamp");
    play(7, 0, 50, 1'b0, 2, 1'b0, -1, "R3 N7 one slot clamp");
    play(11, 3, 333, 1'b0, 1, 1'b0, -1, "R4 N11 16 slots remainder");
    play(10, 2, 2000, 1'b0, 1, 1'b0, -1, "R5 duty above frame");
    play(8, 3, 77, 1'b1, 2, 1'b0, -1, "R8 inverted output");
    play(9, 2, 300, 1'b0, 2, 1'b1, -1, "R9 gated count");
    play(10, 1, 100, 1'b0, 2, 1'b0, 700, "R6 duty change mid frame");
    play(3, 3, 33, 1'b0, 1, 1'b0, -1, "R1 resolution clamp low");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule